// File: doc/BRIEF.md
# DRAM Refresh Interval Scheduler

This block decides when a DDR2-class memory controller must issue auto-refresh commands. A down-counter measures the refresh interval in clock cycles. Software programs the full-length interval as a cycle count. A two-bit temperature range code selects either that count or half of it, and the choice is made each time the counter reloads. Each expiry of the counter adds one refresh to a debt counter. Each refresh that the command arbiter accepts removes one.

The refresh request is a valid/ready pair. The scheduler drives `ref_req` or `ref_urgent` as valid, and the arbiter answers with `ref_grant` as ready. A refresh is accepted on any rising clock edge at which one of the two requests is high and `ref_grant` is high. The arbiter may hold off a normal request for as long as it likes. Holding off raises the debt, and once the debt reaches eight the request turns urgent. A grant while neither request is high has no effect. After each accepted refresh, both requests stay low for the programmed tRFC cycle count, so that back-to-back refreshes are spaced correctly.

The same interval expiries drive two further outputs. A row-open guard raises a flag once a row has stayed open for nine intervals. A self-refresh exit timer drops `sr_ready` for tRFC plus an extra programmed cycle count; that extra count is the 10 ns margin, rounded up to whole cycles by whoever sets it.

Top module: `refresh_sched`

## Requirements
- R1: While reset is high and on the cycle after it, `ref_req`, `ref_urgent` and `row_limit` are low and `sr_ready` is high. After reset the first interval lasts `base_cycles` cycles, whatever the temperature code.
- R2: An interval loaded while `temp_code` is 2'b00 lasts `base_cycles` cycles. An interval loaded while `temp_code` is 2'b01, 2'b10 or 2'b11 lasts floor(`base_cycles`/2) cycles.
- R3: A change of `temp_code` in the middle of an interval does not alter that interval. It takes effect only from the next reload.
- R4: Each interval expiry raises the refresh debt by one. Each accepted refresh (a request high together with `ref_grant` high at a clock edge) lowers it by one.
- R5: `ref_req` is high only while the debt is 1 to 7. `ref_urgent` is high only while the debt is 8. The two are never high together.
- R6: The debt never exceeds 8. Expiries at a debt of 8 are dropped, so that from saturation exactly eight acceptances are needed to clear it.
- R7: After an accepted refresh, both requests stay low for `trfc_cycles` cycles. `ref_grant` while neither request is high leaves the debt unchanged.
- R8: `row_limit` rises on the ninth interval expiry counted while `row_open` has been continuously high. It falls in the cycle after `row_open` goes low.
- R9: A one-cycle `sr_exit` pulse makes `sr_ready` low for exactly `trfc_cycles` + `srx_extra_cycles` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_code | input | 2 | Case-temperature range: 00 normal, 01/10/11 hot (half interval) |
| base_cycles | input | CNT_W | Full refresh interval in cycles (at least 4) |
| trfc_cycles | input | CNT_W | Refresh cycle time in cycles |
| srx_extra_cycles | input | CNT_W | Extra self-refresh exit margin in cycles |
| ref_grant | input | 1 | Arbiter accepts the pending refresh (ready) |
| row_open | input | 1 | A row is currently open |
| sr_exit | input | 1 | Pulse: self-refresh has just been exited |
| ref_req | output | 1 | Normal refresh request (valid) |
| ref_urgent | output | 1 | Urgent refresh request, debt at its limit (valid) |
| row_limit | output | 1 | Row has been open for nine intervals |
| sr_ready | output | 1 | Self-refresh exit wait has elapsed |

## Verification
The interval is measured from one request to the next for every temperature code and for an odd and an even base count. This separates the full interval from the half one, and floor rounding from ceiling rounding. A code change in the middle of an interval tells a timer that reloads at expiry from one that reacts at once. Letting the debt run to saturation and then holding the grant high shows where normal turns urgent, how many acceptances clearing takes, and the tRFC gap between acceptances. Separate tests cover the row-open guard, the self-refresh exit wait, and a grant given while no refresh is owed.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  typedef enum logic [1:0] {
    TEMP_NORMAL = 2'b00,
    TEMP_WARM   = 2'b01,
    TEMP_HOT    = 2'b10,
    TEMP_SPARE  = 2'b11
  } temp_range_t;

  // Any range above normal uses the halved interval; the spare code is
  // treated as hot so that an unexpected value errs toward more refresh.
  function automatic logic needs_half(input temp_range_t t);
    return t != TEMP_NORMAL;
  endfunction
endpackage

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       temp_code,
  input  logic [CNT_W-1:0] base_cycles,
  output logic             tick
);
  import refresh_pkg::*;

  logic [CNT_W-1:0] remain;
  logic [CNT_W-1:0] reload;

  always_comb begin
    if (needs_half(temp_range_t'(temp_code))) reload = base_cycles >> 1;
    else                                      reload = base_cycles;
  end

  assign tick = (remain == '0);

  always_ff @(posedge clk) begin
    if (rst)       remain <= base_cycles - 1'b1;
    else if (tick) remain <= reload - 1'b1;
    else           remain <= remain - 1'b1;
  end

  assert_countdown_R2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> remain == $past(remain) - 1'b1);
endmodule

// File: rtl/debt_tracker.sv
module debt_tracker #(
  parameter int DEBT_MAX = 8,
  localparam int DW = $clog2(DEBT_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          accept,
  output logic [DW-1:0] debt
);
  localparam logic [DW-1:0] CAP = DW'(DEBT_MAX);

  always_ff @(posedge clk) begin
    if (rst) debt <= '0;
    else if (tick && !accept) begin
      if (debt < CAP) debt <= debt + 1'b1;
    end else if (accept && !tick) begin
      if (debt != '0) debt <= debt - 1'b1;
    end
  end

  assert_debt_cap_R6: assert property (@(posedge clk) disable iff (rst)
    debt <= CAP);
  assert_debt_up_R4: assert property (@(posedge clk) disable iff (rst)
    tick && !accept && debt < CAP |=> debt == $past(debt) + 1'b1);
  assert_debt_down_R4: assert property (@(posedge clk) disable iff (rst)
    accept && !tick |=> debt == $past(debt) - 1'b1);
  assert_no_empty_accept_R7: assert property (@(posedge clk) disable iff (rst)
    accept |-> debt != '0);
endmodule

// File: rtl/wait_timer.sv
module wait_timer #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] load,
  output logic         busy
);
  logic [W-1:0] left;

  assign busy = (left != '0);

  always_ff @(posedge clk) begin
    if (rst)        left <= '0;
    else if (start) left <= load;
    else if (busy)  left <= left - 1'b1;
  end

  assert_wait_start_R9: assert property (@(posedge clk) disable iff (rst)
    start && load != '0 |=> busy);
endmodule

// File: rtl/row_guard.sv
module row_guard #(
  parameter int ROW_TICKS = 9,
  localparam int RW = $clog2(ROW_TICKS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic row_open,
  input  logic tick,
  output logic limit
);
  localparam logic [RW-1:0] LIM = RW'(ROW_TICKS);
  logic [RW-1:0] seen;

  assign limit = (seen == LIM);

  always_ff @(posedge clk) begin
    if (rst || !row_open)       seen <= '0;
    else if (tick && seen < LIM) seen <= seen + 1'b1;
  end

  assert_limit_on_tick_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(limit) |-> $past(tick) && $past(row_open));
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int CNT_W     = 16,
  parameter int DEBT_MAX  = 8,
  parameter int ROW_TICKS = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       temp_code,
  input  logic [CNT_W-1:0] base_cycles,
  input  logic [CNT_W-1:0] trfc_cycles,
  input  logic [CNT_W-1:0] srx_extra_cycles,
  input  logic             ref_grant,
  input  logic             row_open,
  input  logic             sr_exit,
  output logic             ref_req,
  output logic             ref_urgent,
  output logic             row_limit,
  output logic             sr_ready
);
  localparam int DW = $clog2(DEBT_MAX + 1);
  localparam int WW = CNT_W + 1;
  localparam logic [DW-1:0] CAP = DW'(DEBT_MAX);

  logic          tick;
  logic          accept;
  logic          rfc_busy;
  logic          srx_busy;
  logic [DW-1:0] debt;
  logic [WW-1:0] srx_total;

  interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .temp_code(temp_code),
    .base_cycles(base_cycles), .tick(tick));

  debt_tracker #(.DEBT_MAX(DEBT_MAX)) u_debt (
    .clk(clk), .rst(rst), .tick(tick), .accept(accept), .debt(debt));

  wait_timer #(.W(WW)) u_rfc_hold (
    .clk(clk), .rst(rst), .start(accept),
    .load({1'b0, trfc_cycles}), .busy(rfc_busy));

  assign srx_total = {1'b0, trfc_cycles} + {1'b0, srx_extra_cycles};

  wait_timer #(.W(WW)) u_srx_wait (
    .clk(clk), .rst(rst), .start(sr_exit),
    .load(srx_total), .busy(srx_busy));

  row_guard #(.ROW_TICKS(ROW_TICKS)) u_row (
    .clk(clk), .rst(rst), .row_open(row_open), .tick(tick),
    .limit(row_limit));

  assign ref_req    = !rfc_busy && (debt != '0) && (debt < CAP);
  assign ref_urgent = !rfc_busy && (debt == CAP);
  assign accept     = (ref_req || ref_urgent) && ref_grant;
  assign sr_ready   = !srx_busy;

  assert_hold_after_accept_R7: assert property (@(posedge clk) disable iff (rst)
    accept && trfc_cycles != '0 |=> !ref_req && !ref_urgent);
  assert_req_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    $countones({ref_req, ref_urgent}) <= 1);
  assert_srx_drop_R9: assert property (@(posedge clk) disable iff (rst)
    sr_exit && srx_total != '0 |=> !sr_ready);
endmodule

// File: tb/refresh_sched_bench.sv
module refresh_sched_bench;
  localparam int CNT_W = 16;
  localparam int NV = 6;
  // {temp_code, base_cycles, expected interval after the first reload}
  localparam int VEC [NV][3] = '{
    '{0, 40, 40}, '{1, 40, 20}, '{2, 40, 20},
    '{3, 40, 20}, '{0, 61, 61}, '{2, 61, 30}};

  logic clk = 0;
  logic rst = 1;
  logic [1:0] temp_code = 0;
  logic [CNT_W-1:0] base_cycles = 16'd40;
  logic [CNT_W-1:0] trfc_cycles = 16'd2;
  logic [CNT_W-1:0] srx_extra_cycles = 16'd0;
  logic ref_grant = 0, row_open = 0, sr_exit = 0;
  logic ref_req, ref_urgent, row_limit, sr_ready;

  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  refresh_sched #(.CNT_W(CNT_W)) u_refresh_sched (
    .clk(clk), .rst(rst), .temp_code(temp_code), .base_cycles(base_cycles),
    .trfc_cycles(trfc_cycles), .srx_extra_cycles(srx_extra_cycles),
    .ref_grant(ref_grant), .row_open(row_open), .sr_exit(sr_exit),
    .ref_req(ref_req), .ref_urgent(ref_urgent), .row_limit(row_limit),
    .sr_ready(sr_ready));

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int t, input int b, input int rfc);
    rst = 1; ref_grant = 0; sr_exit = 0;
    temp_code = 2'(t); base_cycles = CNT_W'(b); trfc_cycles = CNT_W'(rfc);
    @(negedge clk); @(negedge clk);
    rst = 0;
  endtask

  // counts negedges until ref_req is seen high
  task automatic wait_req(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!ref_req);
  endtask

  // grants the pending request, then counts to the next request
  task automatic grant_measure(output int n, input int flip_at, input int new_t);
    ref_grant = 1;
    @(negedge clk); ref_grant = 0; n = 1;
    while (!ref_req) begin
      @(negedge clk); n++;
      if (n == flip_at) temp_code = 2'(new_t);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n;
    int acc, last, gap_bad;

    // R1: reset state
    do_reset(1, 40, 2);
    rst = 1; @(negedge clk);
    check("R1 reset ref_req", int'(ref_req), 0);
    check("R1 reset ref_urgent", int'(ref_urgent), 0);
    check("R1 reset row_limit", int'(row_limit), 0);
    check("R1 reset sr_ready", int'(sr_ready), 1);

    // R1/R2: vector table walk
    for (int i = 0; i < NV; i++) begin
      do_reset(VEC[i][0], VEC[i][1], 2);
      wait_req(n);
      check($sformatf("R1 first interval vec%0d", i), n, VEC[i][1]);
      grant_measure(n, -1, 0);
      check($sformatf("R2 interval vec%0d", i), n, VEC[i][2]);
    end

    // R3: mid-interval code change applies only at next reload
    do_reset(0, 40, 2);
    wait_req(n);
    grant_measure(n, 10, 1);
    check("R3 interval after mid change", n, 40);
    grant_measure(n, -1, 1);
    check("R3 interval after reload", n, 20);

    // R7: grant while nothing owed is ignored
    do_reset(0, 40, 2);
    ref_grant = 1;
    repeat (30) @(negedge clk);
    ref_grant = 0;
    repeat (10) @(negedge clk);
    check("R7 idle grant req", int'(ref_req), 1);
    check("R7 idle grant urgent", int'(ref_urgent), 0);

    // R4/R5/R6/R7: debt build-up, saturation and drain
    do_reset(0, 100, 3);
    repeat (705) @(negedge clk);
    check("R5 debt 7 req", int'(ref_req), 1);
    check("R5 debt 7 urgent", int'(ref_urgent), 0);
    repeat (300) @(negedge clk);
    check("R5 saturated urgent", int'(ref_urgent), 1);
    check("R5 saturated req", int'(ref_req), 0);
    ref_grant = 1; acc = 0; last = -1; gap_bad = 0;
    for (int i = 0; i < 60; i++) begin
      if (ref_req || ref_urgent) begin
        if (last >= 0 && i - last != 4) gap_bad++;
        if (acc == 1) check("R5 after one grant urgent", int'(ref_urgent), 0);
        acc++; last = i;
      end
      @(negedge clk);
    end
    ref_grant = 0;
    check("R6 acceptances to drain", acc, 8);
    check("R7 tRFC gap violations", gap_bad, 0);
    check("R4 drained req", int'(ref_req || ref_urgent), 0);

    // R8: row-open limit after nine intervals
    row_open = 1;
    do_reset(0, 20, 2);
    repeat (179) @(negedge clk);
    check("R8 row_limit before ninth", int'(row_limit), 0);
    @(negedge clk);
    check("R8 row_limit at ninth", int'(row_limit), 1);
    repeat (5) @(negedge clk);
    row_open = 0;
    @(negedge clk);
    check("R8 row_limit cleared", int'(row_limit), 0);

    // R9: self-refresh exit wait
    do_reset(0, 1000, 5);
    srx_extra_cycles = 16'd3;
    repeat (4) @(negedge clk);
    sr_exit = 1;
    @(negedge clk); sr_exit = 0;
    n = 0;
    while (!sr_ready && n < 100) begin n++; @(negedge clk); end
    check("R9 sr_ready low cycles", n, 8);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule